// File: doc/BRIEF.md
# Padded Vertex Count Calculator

This block turns an unsigned vertex count into the padded count that a thread dispatcher launches per instance. The padded count is chosen so that vertex and instance numbers can be split back out of a flat thread index with a cheap divider: it is always an odd factor from {1, 3, 5, 7, 9} times a power of two. It is not the next power of two, so fewer surplus threads are launched.

Counts below twenty come from a small fixed table. Larger counts are rounded using the leading set bit and the three bits just below it. Every result is a multiple of four and strictly greater than the input, even when the input is already of the padded form. Besides the padded value, the block reports the same number as an odd-factor code `m` and a shift `s`, with padded = (2m+1)·2^s. A caller such as an attribute fetch unit can then program its modulus or divisor directly.

The result is registered once. A valid flag travels with each request, and a new count can be presented every cycle.

Top module: `padded_vertex_calc`

## Requirements
- R1: Counts 0, 1 and 2 give a padded value of 4, with code 0 and shift 2.
- R2: Counts 3 to 19 follow the small table: 3 gives 4 (code 0, shift 2); 4–7 give 8 (code 0, shift 3); 8–11 give 12 (code 1, shift 2); 12–15 give 16 (code 0, shift 4); 16–19 give 20 (code 2, shift 2).
- R3: For counts of 20 and above, let n be the number of bits below the leading set bit and its three lower neighbours, read as a 4-bit pattern. Pattern 1000 gives code 4, shift n. Pattern 1001 gives code 2, shift n+1. Patterns 1010–1011 give code 1, shift n+2. Patterns 1100–1101 give code 3, shift n+1. Patterns 1110–1111 give code 0, shift n+4. For example, 70 gives 72 (code 4, shift 3).
- R4: The padded value is strictly greater than the input count.
- R5: The padded value is a multiple of four, so the shift is never below 2.
- R6: The odd code is in 0..4, and the padded output equals (2·code+1) shifted left by the shift output.
- R7: `pad_valid` rises exactly one clock after a cycle with `cnt_valid` high and is low one clock after a cycle with `cnt_valid` low. Results come out in request order.
- R8: While `rst_n` is low at a clock edge, the next outputs are `pad_valid`=0, `pad_out`=0, `pad_odd_code`=0 and `pad_shift`=0.
- R9: The output is four bits wider than the input, so the largest inputs do not overflow: an input with bit 31 set and pattern 111x gives 2^32 (code 0, shift 32).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_valid | input | 1 | A count is presented this cycle |
| cnt_in | input | 32 | Unsigned vertex count |
| pad_valid | output | 1 | Result registers hold a new result |
| pad_out | output | 36 | Padded vertex count |
| pad_odd_code | output | 3 | Odd factor code m, factor = 2m+1 |
| pad_shift | output | 6 | Power-of-two exponent s |

## Verification
The bench builds the block with its default 32-bit count width, which makes the output 36 bits and the shift 6 bits. A complete sweep of every count below 2^16 reaches each row of the small table, both edges of each row and every 4-bit pattern at shifts up to 16. Random full-width counts with a random leading-bit position extend this to the upper bits. Directed corners at 2^31 and all-ones exercise the widest results and the extra output bits.

// File: rtl/pvc_pkg.sv
// Package: shared types and constants for the padded vertex count calculator.
// Assumes the odd factor set is {1,3,5,7,9}, encoded as m with factor 2m+1.
package pvc_pkg;
    localparam int ODD_CODE_W  = 3;
    localparam int SMALL_LIMIT = 20;

    typedef logic [ODD_CODE_W-1:0] odd_code_t;

    // Odd factor (2m+1) for a code m, as a 4-bit value
    function automatic logic [3:0] odd_factor(input odd_code_t m);
        return {m, 1'b1};
    endfunction
endpackage

// File: rtl/pvc_msb_find.sv
// Module: leading-one finder. Gives the bit position of the highest set bit.
// Assumes a zero input is handled by the caller; pos is then 0.
module pvc_msb_find #(
    parameter int CNT_W = 32,
    localparam int POS_W = $clog2(CNT_W)
) (
    input  logic [CNT_W-1:0] vec,
    output logic [POS_W-1:0] pos
);
    logic [CNT_W-1:0] is_top;

    // Mark the single bit that is set with no set bit above it
    generate
        for (genvar i = 0; i < CNT_W; i++) begin : g_top
            if (i == CNT_W - 1) begin : g_last
                assign is_top[i] = vec[i];
            end else begin : g_mid
                assign is_top[i] = vec[i] & ~(|vec[CNT_W-1:i+1]);
            end
        end
    endgenerate

    // Encode the one-hot marker into a binary position
    always_comb begin
        pos = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (is_top[i]) pos = pos | POS_W'(i);
        end
    end
endmodule

// File: rtl/pvc_small_table.sv
// Module: fixed table for counts below 20, indexed by count bits [4:2].
// Assumes the caller selects this path only when the count is below 20.
module pvc_small_table
    import pvc_pkg::*;
#(
    parameter int SH_W = 6
) (
    input  logic [2:0]      idx,
    output odd_code_t       code,
    output logic [SH_W-1:0] shift
);
    // Map each group of four counts to its padded factor and exponent
    always_comb begin
        case (idx)
            3'd1:    begin code = 3'd0; shift = SH_W'(3); end
            3'd2:    begin code = 3'd1; shift = SH_W'(2); end
            3'd3:    begin code = 3'd0; shift = SH_W'(4); end
            3'd4:    begin code = 3'd2; shift = SH_W'(2); end
            default: begin code = 3'd0; shift = SH_W'(2); end
        endcase
    end
endmodule

// File: rtl/pvc_pattern_map.sv
// Module: general rounding rule. Extracts the leading bit and three lower
// bits as a pattern and maps it to an odd code and shift.
// Assumes the count is at least 20, so the leading bit is at position 4 or above.
module pvc_pattern_map
    import pvc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SH_W  = 6,
    localparam int POS_W = $clog2(CNT_W)
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [POS_W-1:0] pos,
    output odd_code_t        code,
    output logic [SH_W-1:0]  shift
);
    localparam logic [SH_W-1:0] ONE  = SH_W'(1);
    localparam logic [SH_W-1:0] TWO  = SH_W'(2);
    localparam logic [SH_W-1:0] FOUR = SH_W'(4);

    logic [3:0]      pattern;
    logic [SH_W-1:0] n_low;

    // Gather the leading bit and its three lower neighbours
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            if (pos >= POS_W'(k)) pattern[3-k] = cnt[pos - POS_W'(k)];
            else                  pattern[3-k] = 1'b0;
        end
    end

    // Count of bits below the four-bit pattern
    assign n_low = (pos >= POS_W'(3)) ? (SH_W'(pos) - SH_W'(3)) : '0;

    // Round the pattern up to the next odd-times-power-of-two value
    always_comb begin
        case (pattern)
            4'b1000:          begin code = 3'd4; shift = n_low;        end
            4'b1001:          begin code = 3'd2; shift = n_low + ONE;  end
            4'b1010, 4'b1011: begin code = 3'd1; shift = n_low + TWO;  end
            4'b1100, 4'b1101: begin code = 3'd3; shift = n_low + ONE;  end
            default:          begin code = 3'd0; shift = n_low + FOUR; end
        endcase
    end
endmodule

// File: rtl/pvc_compose.sv
// Module: rebuilds the padded value as (2m+1) shifted left by s.
// Assumes s never exceeds OUT_W-4, so no set bit is lost.
module pvc_compose
    import pvc_pkg::*;
#(
    parameter int OUT_W = 36,
    parameter int SH_W  = 6
) (
    input  odd_code_t        code,
    input  logic [SH_W-1:0]  shift,
    output logic [OUT_W-1:0] padded
);
    // Place the odd factor at the exponent position
    assign padded = OUT_W'(odd_factor(code)) << shift;
endmodule

// File: rtl/padded_vertex_calc.sv
// Module: padded vertex count calculator, top level. Chooses the small table
// or the general rule, composes the padded value and registers it for one cycle.
// Assumes a synchronous active-low reset; one request may arrive every cycle.
module padded_vertex_calc
    import pvc_pkg::*;
#(
    parameter int CNT_W = 32,
    localparam int OUT_W = CNT_W + 4,
    localparam int SH_W  = $clog2(CNT_W + 1),
    localparam int POS_W = $clog2(CNT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_valid,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             pad_valid,
    output logic [OUT_W-1:0] pad_out,
    output logic [2:0]       pad_odd_code,
    output logic [SH_W-1:0]  pad_shift
);
    localparam logic [CNT_W-1:0] SMALL_MAX = CNT_W'(SMALL_LIMIT);

    logic [POS_W-1:0] msb_pos;
    odd_code_t        small_code, big_code, sel_code;
    logic [SH_W-1:0]  small_shift, big_shift, sel_shift;
    logic [OUT_W-1:0] sel_padded;
    logic             use_small;

    pvc_msb_find #(.CNT_W(CNT_W)) u_msb (
        .vec (cnt_in),
        .pos (msb_pos)
    );

    pvc_small_table #(.SH_W(SH_W)) u_small (
        .idx   (cnt_in[4:2]),
        .code  (small_code),
        .shift (small_shift)
    );

    pvc_pattern_map #(.CNT_W(CNT_W), .SH_W(SH_W)) u_map (
        .cnt   (cnt_in),
        .pos   (msb_pos),
        .code  (big_code),
        .shift (big_shift)
    );

    // Pick the small table below the threshold, the general rule above it
    assign use_small = (cnt_in < SMALL_MAX);
    assign sel_code  = use_small ? small_code  : big_code;
    assign sel_shift = use_small ? small_shift : big_shift;

    pvc_compose #(.OUT_W(OUT_W), .SH_W(SH_W)) u_comp (
        .code   (sel_code),
        .shift  (sel_shift),
        .padded (sel_padded)
    );

    // Result register: load on each valid request, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_valid    <= 1'b0;
            pad_out      <= '0;
            pad_odd_code <= '0;
            pad_shift    <= '0;
        end else begin
            pad_valid <= cnt_valid;
            if (cnt_valid) begin
                pad_out      <= sel_padded;
                pad_odd_code <= sel_code;
                pad_shift    <= sel_shift;
            end
        end
    end
endmodule

// File: rtl/pvc_checker.sv
// Module: property checker for the padded vertex count calculator.
// Bound into every instance of the top module.
module pvc_checker #(
    parameter int CNT_W = 32,
    localparam int OUT_W = CNT_W + 4,
    localparam int SH_W  = $clog2(CNT_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_valid,
    input logic [CNT_W-1:0] cnt_in,
    input logic             pad_valid,
    input logic [OUT_W-1:0] pad_out,
    input logic [2:0]       pad_odd_code,
    input logic [SH_W-1:0]  pad_shift
);
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (!pad_valid && pad_out == '0 && pad_odd_code == '0 && pad_shift == '0));

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid |=> pad_valid);

    assert_idle_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_valid |=> !pad_valid);

    assert_above_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid |=> (OUT_W'($past(cnt_in)) < pad_out));

    // Padding never more than doubles the count plus four (tightness of R3)
    assert_tight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid |=> (pad_out <= (OUT_W'($past(cnt_in)) << 1) + OUT_W'(4)));

    assert_mult_four_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pad_valid |-> (pad_out[1:0] == 2'b00));

    assert_shift_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pad_valid |-> (pad_shift >= SH_W'(2)));

    assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pad_valid |-> (pad_odd_code <= 3'd4));
endmodule

bind padded_vertex_calc pvc_checker #(.CNT_W(CNT_W)) u_pvc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_valid    (cnt_valid),
    .cnt_in       (cnt_in),
    .pad_valid    (pad_valid),
    .pad_out      (pad_out),
    .pad_odd_code (pad_odd_code),
    .pad_shift    (pad_shift)
);

// File: tb/padded_vertex_calc_bench.sv
// Scoreboard bench: the driver queues expected results, the monitor compares.
module padded_vertex_calc_bench;
    localparam int CNT_W = 32;
    localparam int OUT_W = 36;
    localparam int SH_W  = 6;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [OUT_W-1:0] pad;
        logic [2:0]       code;
        logic [SH_W-1:0]  sh;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_valid = 1'b0;
    logic [CNT_W-1:0] cnt_in = '0;
    logic             pad_valid;
    logic [OUT_W-1:0] pad_out;
    logic [2:0]       pad_odd_code;
    logic [SH_W-1:0]  pad_shift;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    padded_vertex_calc u_padded_vertex_calc (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_valid    (cnt_valid),
        .cnt_in       (cnt_in),
        .pad_valid    (pad_valid),
        .pad_out      (pad_out),
        .pad_odd_code (pad_odd_code),
        .pad_shift    (pad_shift)
    );

    // Reference model written from the requirements
    function automatic exp_t ref_model(input logic [CNT_W-1:0] c);
        exp_t e;
        int   p;
        int   n;
        logic [3:0] top;
        e.cnt = c;
        p = 0;
        if (c < 3)       begin e.code = 0; e.sh = 2; end       // R1
        else if (c < 4)  begin e.code = 0; e.sh = 2; end       // R2
        else if (c < 8)  begin e.code = 0; e.sh = 3; end
        else if (c < 12) begin e.code = 1; e.sh = 2; end
        else if (c < 16) begin e.code = 0; e.sh = 4; end
        else if (c < 20) begin e.code = 2; e.sh = 2; end
        else begin                                              // R3
            for (int i = 0; i < CNT_W; i++) if (c[i]) p = i;
            n   = p - 3;
            top = 4'(c >> n);
            case (top)
                4'b1000:          begin e.code = 4; e.sh = SH_W'(n);     end
                4'b1001:          begin e.code = 2; e.sh = SH_W'(n + 1); end
                4'b1010, 4'b1011: begin e.code = 1; e.sh = SH_W'(n + 2); end
                4'b1100, 4'b1101: begin e.code = 3; e.sh = SH_W'(n + 1); end
                default:          begin e.code = 0; e.sh = SH_W'(n + 4); end
            endcase
        end
        e.pad = OUT_W'(2 * int'(e.code) + 1) << e.sh;
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [CNT_W-1:0] c);
        @(negedge clk);
        cnt_valid = 1'b1;
        cnt_in    = c;
        q.push_back(ref_model(c));
    endtask

    task automatic idle();
        @(negedge clk);
        cnt_valid = 1'b0;
    endtask

    // Monitor: pop and compare one expected item per valid result
    always @(posedge clk) begin
        #1;
        if (rst_n && pad_valid && !finished) begin
            if (q.size() == 0) begin
                check(1'b0, "R7", "unexpected result", 64'(pad_out), 64'd0);
            end else begin
                exp_t e;
                string req;
                e = q.pop_front();
                req = (e.cnt < 3) ? "R1" : (e.cnt < 20) ? "R2" :
                      (e.cnt[31] ? "R9" : "R3");
                check(pad_out == e.pad, req, "padded", 64'(pad_out), 64'(e.pad));
                check(pad_odd_code == e.code && pad_shift == e.sh, "R6", "code/shift",
                      {pad_odd_code, 8'h0, 2'b0, pad_shift}, {e.code, 8'h0, 2'b0, e.sh});
                check(pad_out > OUT_W'(e.cnt), "R4", "above input",
                      64'(pad_out), 64'(e.cnt));
                check(pad_out[1:0] == 2'b00, "R5", "multiple of four",
                      64'(pad_out[1:0]), 64'd0);
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: an expired timer counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        // R8: outputs clear while reset is held, even with a request present
        cnt_valid = 1'b1;
        cnt_in    = 32'd70;
        repeat (3) @(posedge clk);
        #1;
        check(!pad_valid && pad_out == '0 && pad_odd_code == '0 && pad_shift == '0,
              "R8", "reset state", 64'(pad_out), 64'd0);
        @(negedge clk);
        cnt_valid = 1'b0;
        rst_n     = 1'b1;

        // R7: no result one clock after an idle cycle
        idle();
        @(posedge clk);
        #1;
        check(!pad_valid, "R7", "idle gives no valid", 64'(pad_valid), 64'd0);

        // Directed corners: R1, R2 row edges, R3 example and threshold, R9 top
        drive(32'd0);  drive(32'd2);  drive(32'd3);  drive(32'd19);
        drive(32'd20); drive(32'd70); drive(32'd72);
        drive(32'h8000_0000); drive(32'hFFFF_FFFF); drive(32'hE000_0000);
        idle();

        // Exhaustive sweep of all counts below 2^16, with a gap every 4096
        for (int c = 0; c < 65536; c++) begin
            drive(CNT_W'(c));
            if ((c % 4096) == 4095) idle();
        end

        // Random full-width counts with a random leading-bit position
        for (int k = 0; k < 2000; k++) begin
            drive($urandom() >> ($urandom() % 32));
        end
        idle();
        repeat (3) @(negedge clk);

        // R7: every queued request has produced its result, in order
        check(q.size() == 0, "R7", "results outstanding", 64'(q.size()), 64'd0);
        finish_run();
    end
endmodule